// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of virtual-to-physical page translations. Each cycle it may accept one lookup made of a virtual page number, the identifier of the address space that issued it and an access kind (load, store or instruction fetch). Every stored entry is compared at once. One clock later the block reports one of three outcomes: a hit with the physical frame number, a miss, or a permission fault.

On a miss, the unit that walks the page tables writes the translation back through a refill port. The entry to replace is chosen from the replaceable entries, taking an empty one first and otherwise the one used least recently. An entry written with its pin flag set is never replaced and survives every flush. Two flush commands are provided: one clears all unpinned entries, the other clears only the unpinned entries of one address space.

Top module: `tlb_asid`

## Requirements
- R1: A lookup request sampled at a clock edge produces exactly one response, with `rs_valid_o` high for one cycle, right after that edge. Without a request, `rs_valid_o` stays low.
- R2: A lookup hits only if some valid entry matches both the page number and the address-space identifier. A hit drives `rs_hit_o` and returns that entry's frame number on `rs_pfn_o`.
- R3: When no valid entry matches both fields, the response has `rs_miss_o` high and `rs_pfn_o` equal to zero.
- R4: A refill writes the entry so that the next lookup of that page and identifier hits. While an unpinned entry is invalid, the refill goes to the lowest-numbered such entry and `fill_err_o` stays low.
- R5: When every unpinned entry is valid, a refill replaces the unpinned entry that was least recently hit or written. A permitted hit and a refill each make their entry the most recent.
- R6: An entry written with `fill_wired_i` high is never chosen for replacement, and neither flush command clears it.
- R7: Permission bits are `fill_perm_i[0]` read, `[1]` write and `[2]` execute. The access codes are 0 load (needs read), 1 store (needs write), 2 fetch (needs execute) and 3 reserved (always a violation). A matching entry that lacks the needed bit gives `rs_fault_o` high, `rs_hit_o` low and `rs_pfn_o` zero.
- R8: `flush_all_i` invalidates every unpinned entry in one cycle.
- R9: `flush_asid_i` invalidates only the unpinned entries whose identifier equals `flush_id_i`. Entries of other identifiers keep hitting.
- R10: When all entries are pinned, a refill writes nothing, and `fill_err_o` pulses high in the cycle after the refill request.
- R11: After reset every entry is invalid and unpinned, and `rs_valid_o` and `fill_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_vpn_i | input | VPN_W | Virtual page number to translate |
| lk_asid_i | input | ASID_W | Address-space identifier of the request |
| lk_acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| rs_valid_o | output | 1 | Response strobe, one cycle after the request |
| rs_hit_o | output | 1 | Permitted hit |
| rs_miss_o | output | 1 | No matching entry |
| rs_fault_o | output | 1 | Match with a permission violation |
| rs_pfn_o | output | PFN_W | Physical frame number; zero unless the response is a hit |
| fill_valid_i | input | 1 | Refill request |
| fill_vpn_i | input | VPN_W | Refill page number |
| fill_asid_i | input | ASID_W | Refill identifier |
| fill_pfn_i | input | PFN_W | Refill frame number |
| fill_perm_i | input | 3 | Refill permissions {execute, write, read} |
| fill_wired_i | input | 1 | Pin the refilled entry against replacement and flush |
| fill_err_o | output | 1 | Refill rejected because all entries are pinned |
| flush_all_i | input | 1 | Invalidate all unpinned entries |
| flush_asid_i | input | 1 | Invalidate the unpinned entries of one identifier |
| flush_id_i | input | ASID_W | Identifier used by the per-identifier flush |

## Verification
Lookups are made with the same page number under several identifiers, so that a match on the page number alone is told apart from a match on page number and identifier together. Each access kind is run against entries that hold different subsets of the permission bits, which shows whether a fault comes from the right bit. Refill is exercised in three states: with empty slots, with all slots full after a chosen pattern of hits, and with every slot pinned. These show the empty-first choice, the least-recently-used choice and the rejection apart from each other. The two flush commands are issued while the cache holds pinned entries and entries from several identifiers.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_W = 3;

  // perm: [0] read, [1] write, [2] execute
  function automatic logic perm_ok(input logic [PERM_W-1:0] perm, input acc_e acc);
    logic ok;
    case (acc)
      ACC_LOAD:  ok = perm[0];
      ACC_STORE: ok = perm[1];
      ACC_FETCH: ok = perm[2];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic [ENTRIES-1:0]             vld_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_i,
  input  logic [ENTRIES-1:0][ASID_W-1:0] asid_i,
  input  logic [VPN_W-1:0]               key_vpn_i,
  input  logic [ASID_W-1:0]              key_asid_i,
  output logic [ENTRIES-1:0]             hit_o
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_o[g] = vld_i[g] && (vpn_i[g] == key_vpn_i) && (asid_i[g] == key_asid_i);
  end

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               touch_i,
  input  logic [IW-1:0]      touch_idx_i,
  input  logic [ENTRIES-1:0] vld_i,
  input  logic [ENTRIES-1:0] wired_i,
  output logic [IW-1:0]      victim_idx_o,
  output logic               victim_ok_o
);

  // age 0 = most recent; ages always form a permutation
  logic [ENTRIES-1:0][IW-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IW'(i);
    end else if (touch_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IW'(i) == touch_idx_i)              age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  logic          found_inv, have_best;
  logic [IW-1:0] inv_idx, best_idx, best_age;

  always_comb begin
    found_inv = 1'b0;
    have_best = 1'b0;
    inv_idx   = '0;
    best_idx  = '0;
    best_age  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!wired_i[i]) begin
        if (!vld_i[i] && !found_inv) begin
          found_inv = 1'b1;
          inv_idx   = IW'(i);
        end
        if (!have_best || age_q[i] > best_age) begin
          have_best = 1'b1;
          best_age  = age_q[i];
          best_idx  = IW'(i);
        end
      end
    end
    victim_idx_o = found_inv ? inv_idx : best_idx;
    victim_ok_o  = have_best;
  end

  p_touch_mru_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> age_q[$past(touch_idx_i)] == '0);

  p_victim_unpinned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_ok_o |-> !wired_i[victim_idx_o]);

endmodule

// File: rtl/tlb_asid.sv
module tlb_asid
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [1:0]        lk_acc_i,
  output logic              rs_valid_o,
  output logic              rs_hit_o,
  output logic              rs_miss_o,
  output logic              rs_fault_o,
  output logic [PFN_W-1:0]  rs_pfn_o,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [2:0]        fill_perm_i,
  input  logic              fill_wired_i,
  output logic              fill_err_o,
  input  logic              flush_all_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] flush_id_i
);

  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]              vld_q, wired_q;
  logic [ENTRIES-1:0][VPN_W-1:0]   vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0]  asid_q;
  logic [ENTRIES-1:0][PFN_W-1:0]   pfn_q;
  logic [ENTRIES-1:0][PERM_W-1:0]  perm_q;

  // search
  logic [ENTRIES-1:0] hit_vec;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
    .vld_i      (vld_q),
    .vpn_i      (vpn_q),
    .asid_i     (asid_q),
    .key_vpn_i  (lk_vpn_i),
    .key_asid_i (lk_asid_i),
    .hit_o      (hit_vec)
  );

  logic              hit_any, allowed, lk_ok;
  logic [IW-1:0]     hit_idx;
  logic [PFN_W-1:0]  sel_pfn;
  logic [PERM_W-1:0] sel_perm;

  always_comb begin
    hit_idx  = '0;
    sel_pfn  = '0;
    sel_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = IW'(i);
      sel_pfn  |= {PFN_W{hit_vec[i]}} & pfn_q[i];
      sel_perm |= {PERM_W{hit_vec[i]}} & perm_q[i];
    end
  end

  assign hit_any = |hit_vec;
  assign allowed = perm_ok(sel_perm, acc_e'(lk_acc_i));
  assign lk_ok   = lk_valid_i && hit_any && allowed;

  // replacement
  logic          victim_ok, do_fill, touch;
  logic [IW-1:0] victim_idx, touch_idx;

  assign do_fill   = fill_valid_i && victim_ok;
  assign touch     = do_fill || lk_ok;
  assign touch_idx = do_fill ? victim_idx : hit_idx;

  tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .touch_i      (touch),
    .touch_idx_i  (touch_idx),
    .vld_i        (vld_q),
    .wired_i      (wired_q),
    .victim_idx_o (victim_idx),
    .victim_ok_o  (victim_ok)
  );

  // flush mask
  logic [ENTRIES-1:0] clr;
  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      clr[i] = !wired_q[i] &&
               (flush_all_i || (flush_asid_i && asid_q[i] == flush_id_i));
  end

  // entry storage; a refill in the same cycle as a flush survives it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      wired_q <= '0;
      vpn_q   <= '0;
      asid_q  <= '0;
      pfn_q   <= '0;
      perm_q  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (do_fill && victim_idx == IW'(i)) begin
          vld_q[i]   <= 1'b1;
          wired_q[i] <= fill_wired_i;
          vpn_q[i]   <= fill_vpn_i;
          asid_q[i]  <= fill_asid_i;
          pfn_q[i]   <= fill_pfn_i;
          perm_q[i]  <= fill_perm_i;
        end else if (clr[i]) begin
          vld_q[i]   <= 1'b0;
        end
      end
    end
  end

  // registered response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs_valid_o <= 1'b0;
      rs_hit_o   <= 1'b0;
      rs_miss_o  <= 1'b0;
      rs_fault_o <= 1'b0;
      rs_pfn_o   <= '0;
      fill_err_o <= 1'b0;
    end else begin
      rs_valid_o <= lk_valid_i;
      rs_hit_o   <= lk_ok;
      rs_miss_o  <= lk_valid_i && !hit_any;
      rs_fault_o <= lk_valid_i && hit_any && !allowed;
      rs_pfn_o   <= lk_ok ? sel_pfn : '0;
      fill_err_o <= fill_valid_i && !victim_ok;
    end
  end

  p_resp_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> rs_valid_o);

  p_no_spurious_resp_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !rs_valid_o);

  p_one_outcome_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_valid_o |-> $onehot({rs_hit_o, rs_miss_o, rs_fault_o}));

  p_pfn_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_valid_o && !rs_hit_o) |-> rs_pfn_o == '0);

  p_pinned_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (vld_q & $past(wired_q)) == $past(wired_q));

  p_flush_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_all_i && !fill_valid_i) |=> (vld_q & ~wired_q) == '0);

  p_fill_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_err_o |-> $past(&wired_q));

endmodule

// File: tb/tlb_asid_tb.sv
module tlb_asid_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic [7:0]  lk_asid = '0;
  logic [1:0]  lk_acc = '0;
  logic        rs_valid_o, rs_hit_o, rs_miss_o, rs_fault_o;
  logic [19:0] rs_pfn_o;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [7:0]  fill_asid = '0;
  logic [19:0] fill_pfn = '0;
  logic [2:0]  fill_perm = '0;
  logic        fill_wired = 1'b0;
  logic        fill_err_o;
  logic        flush_all = 1'b0;
  logic        flush_asid = 1'b0;
  logic [7:0]  flush_id = '0;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  tlb_asid dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid), .lk_vpn_i(lk_vpn), .lk_asid_i(lk_asid), .lk_acc_i(lk_acc),
    .rs_valid_o(rs_valid_o), .rs_hit_o(rs_hit_o), .rs_miss_o(rs_miss_o),
    .rs_fault_o(rs_fault_o), .rs_pfn_o(rs_pfn_o),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_asid_i(fill_asid),
    .fill_pfn_i(fill_pfn), .fill_perm_i(fill_perm), .fill_wired_i(fill_wired),
    .fill_err_o(fill_err_o),
    .flush_all_i(flush_all), .flush_asid_i(flush_asid), .flush_id_i(flush_id)
  );

  localparam logic [1:0] K_HIT = 2'd0, K_MISS = 2'd1, K_FAULT = 2'd2;

  // {vpn, asid, acc, kind, pfn}
  localparam int NV = 10;
  localparam logic [51:0] VEC [NV] = '{
    {20'h00100, 8'd1, 2'd0, K_HIT,   20'h000A0},
    {20'h00100, 8'd2, 2'd0, K_HIT,   20'h000B0},
    {20'h00100, 8'd3, 2'd0, K_MISS,  20'h00000},
    {20'h00103, 8'd1, 2'd0, K_MISS,  20'h00000},
    {20'h00101, 8'd1, 2'd1, K_FAULT, 20'h00000},
    {20'h00101, 8'd1, 2'd0, K_HIT,   20'h000A1},
    {20'h00100, 8'd1, 2'd1, K_HIT,   20'h000A0},
    {20'h00102, 8'd1, 2'd2, K_HIT,   20'h000A2},
    {20'h00100, 8'd1, 2'd2, K_FAULT, 20'h00000},
    {20'h00102, 8'd1, 2'd3, K_FAULT, 20'h00000}
  };
  string vreq [NV] = '{"R2", "R2", "R2", "R3", "R7", "R7", "R7", "R7", "R7", "R7"};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic lookup_chk(input logic [19:0] v, input logic [7:0] a, input logic [1:0] acc,
                            input logic [1:0] kind, input logic [19:0] p, input string req);
    logic [23:0] act, exp;
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v; lk_asid = a; lk_acc = acc;
    @(negedge clk);
    act = {rs_valid_o, rs_hit_o, rs_miss_o, rs_fault_o, rs_pfn_o};
    exp = {1'b1, kind == K_HIT, kind == K_MISS, kind == K_FAULT, p};
    lk_valid = 1'b0;
    check(act == exp, req, {8'h0, act}, {8'h0, exp});
  endtask

  task automatic fill(input logic [19:0] v, input logic [7:0] a, input logic [19:0] p,
                      input logic [2:0] perm, input logic w, output logic err);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = v; fill_asid = a; fill_pfn = p;
    fill_perm = perm; fill_wired = w;
    @(negedge clk);
    err = fill_err_o;
    fill_valid = 1'b0; fill_wired = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic e;
    do_reset();

    // R11: reset state
    check(rs_valid_o == 1'b0 && fill_err_o == 1'b0, "R11", {30'h0, rs_valid_o, fill_err_o}, 32'h0);
    lookup_chk(20'h0, 8'd0, 2'd0, K_MISS, 20'h0, "R11");
    // R1: no request, no response
    @(negedge clk);
    check(rs_valid_o == 1'b0, "R1", {31'h0, rs_valid_o}, 32'h0);

    // population for the vector table
    fill(20'h00100, 8'd1, 20'h000A0, 3'b011, 1'b0, e);
    check(e == 1'b0, "R4", {31'h0, e}, 32'h0);
    fill(20'h00101, 8'd1, 20'h000A1, 3'b001, 1'b0, e);
    fill(20'h00102, 8'd1, 20'h000A2, 3'b101, 1'b0, e);
    fill(20'h00100, 8'd2, 20'h000B0, 3'b111, 1'b0, e);

    for (int k = 0; k < NV; k++)
      lookup_chk(VEC[k][51:32], VEC[k][31:24], VEC[k][23:22], VEC[k][21:20], VEC[k][19:0], vreq[k]);

    // R6 / R8: pinned entry (index 4) survives flush-all
    fill(20'h00200, 8'd1, 20'h000C0, 3'b001, 1'b1, e);
    @(negedge clk); flush_all = 1'b1;
    @(negedge clk); flush_all = 1'b0;
    lookup_chk(20'h00100, 8'd1, 2'd0, K_MISS, 20'h0, "R8");
    lookup_chk(20'h00100, 8'd2, 2'd0, K_MISS, 20'h0, "R8");
    lookup_chk(20'h00200, 8'd1, 2'd0, K_HIT, 20'h000C0, "R6");

    // R4 / R5: refill seven free slots, then LRU replacement
    for (int i = 0; i < 7; i++)
      fill(20'h00300 + 20'(i), 8'd3, 20'h00300 + 20'(i), 3'b001, 1'b0, e);
    lookup_chk(20'h00306, 8'd3, 2'd0, K_HIT, 20'h00306, "R4");
    lookup_chk(20'h00300, 8'd3, 2'd0, K_HIT, 20'h00300, "R5");
    fill(20'h00310, 8'd3, 20'h00310, 3'b001, 1'b0, e); // evicts 0x301
    check(e == 1'b0, "R5", {31'h0, e}, 32'h0);
    lookup_chk(20'h00301, 8'd3, 2'd0, K_MISS, 20'h0, "R5");
    lookup_chk(20'h00300, 8'd3, 2'd0, K_HIT, 20'h00300, "R5");
    lookup_chk(20'h00310, 8'd3, 2'd0, K_HIT, 20'h00310, "R5");
    lookup_chk(20'h00302, 8'd3, 2'd0, K_HIT, 20'h00302, "R5");
    fill(20'h00400, 8'd4, 20'h00400, 3'b001, 1'b0, e); // evicts 0x303
    lookup_chk(20'h00303, 8'd3, 2'd0, K_MISS, 20'h0, "R5");
    lookup_chk(20'h00304, 8'd3, 2'd0, K_HIT, 20'h00304, "R5");

    // R9: flush one identifier, including the pinned entry's identifier
    @(negedge clk); flush_asid = 1'b1; flush_id = 8'd3;
    @(negedge clk); flush_id = 8'd1;
    @(negedge clk); flush_asid = 1'b0;
    lookup_chk(20'h00302, 8'd3, 2'd0, K_MISS, 20'h0, "R9");
    lookup_chk(20'h00400, 8'd4, 2'd0, K_HIT, 20'h00400, "R9");
    lookup_chk(20'h00200, 8'd1, 2'd0, K_HIT, 20'h000C0, "R9");

    // R10: all entries pinned
    do_reset();
    for (int i = 0; i < 8; i++)
      fill(20'h00500 + 20'(i), 8'd5, 20'h00500 + 20'(i), 3'b001, 1'b1, e);
    check(e == 1'b0, "R10", {31'h0, e}, 32'h0);
    fill(20'h005FF, 8'd5, 20'h005FF, 3'b001, 1'b0, e);
    check(e == 1'b1, "R10", {31'h0, e}, 32'h1);
    @(negedge clk);
    check(fill_err_o == 1'b0, "R10", {31'h0, fill_err_o}, 32'h0);
    lookup_chk(20'h005FF, 8'd5, 2'd0, K_MISS, 20'h0, "R10");
    lookup_chk(20'h00507, 8'd5, 2'd0, K_HIT, 20'h00507, "R10");
    lookup_chk(20'h00500, 8'd5, 2'd0, K_HIT, 20'h00500, "R6");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule